// File: doc/BRIEF.md
# Two-Level Priority Interrupt Arbiter

This block decides, for a small 8-bit controller core, which of five interrupt sources is taken and when. The sources are two active-low external pins, two timer overflow flags and one serial flag. A free-running 12-clock machine-cycle counter defines one sample slot per machine cycle. At that slot the arbiter evaluates every enabled request, ranks them by a one-bit priority level and then by a fixed polling order, and issues a one-clock take strobe with a vector index and the level of the winner.

Software configures the block through a small write port. One register holds the global enable and the per-source enables. A second holds the per-source priority bits. A third selects edge or level sensing for each external pin. The arbiter keeps one in-service flag per level so that handlers nest correctly, and a return pulse from the core retires the innermost active level. A return, or a write to the enable or priority register, holds off the next sample slot so that the core finishes one instruction before another interrupt can be taken.

Top module: `irq_arbiter`

## Requirements
- R1: After reset every enable, priority, sense-mode and in-service bit is clear, and `take_o` stays low until software enables a source.
- R2: While the global enable (register 0, bit 5) is clear, no source is taken, whatever its own enable bit holds.
- R3: Source i is eligible only when register 0 bit i is set. The source indices are 0 external pin 0, 1 timer 0, 2 external pin 1, 3 timer 1 and 4 serial.
- R4: The machine-cycle counter restarts at reset. Requests are sampled only on the 9th rising edge of each 12-clock machine cycle, which is the 9th edge after reset release and every 12th edge after it. `take_o` is high for exactly the one clock that follows that edge.
- R5: Register 1 bit i set puts source i at level 1 and clear puts it at level 0. An eligible level-1 request always beats any level-0 request, and `lvl_o` reports the level of the winner.
- R6: Within one level the lowest source index wins, and `vec_o` carries that index (0 to 4).
- R7: In level mode (register 2 bit 0 for pin 0, bit 1 for pin 1, value 0) a pin requests exactly when it is low at the sample edge. A low pulse that spans no sample edge is lost, and a pin held low for a whole machine cycle is always seen.
- R8: In edge mode (register 2 bit = 1) a pin that was high at one sample edge and is low at the next sets a request flag. Taking that source clears the flag, so one falling edge yields one take, however long the pin then stays low.
- R9: While a level-0 handler is in service only a level-1 request can be taken. While a level-1 handler is in service nothing is taken.
- R10: A pulse on `reti_i` clears the level-1 in-service flag if it is set, and otherwise clears the level-0 flag.
- R11: A `reti_i` pulse, or a write to register 0 or 1, that falls in a sample-edge cycle or between two sample edges suppresses the next sample. A write to register 2 does not suppress any sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ext_n_i | input | 2 | Active-low external request pins |
| tmr_ovf_i | input | 2 | Timer 0 and timer 1 overflow flags |
| ser_i | input | 1 | Serial port flag |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register select: 0 enables, 1 priority, 2 sense modes |
| wr_data_i | input | 6 | Write data |
| reti_i | input | 1 | Return-from-interrupt pulse from the core |
| take_o | output | 1 | One-clock strobe: take an interrupt |
| vec_o | output | 3 | Index of the taken source |
| lvl_o | output | 1 | Priority level of the taken source |

## Verification
The embedded properties watch every cycle for the following: a strobe outside the clock after a sample edge, a take while the global enable is off or while a hold-off is active, a level-0 winner chosen over a level-1 candidate, any take during a level-1 handler, and an edge flag that survives its own take. Only the bench scenarios can show that the right source wins. It sweeps every priority setting against every request pattern. Other scenarios show that a short pulse between slots is missed and that a return retires only the inner level. They also show that a sense-mode write leaves the next sample intact.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int NSRC = 5;
  localparam int IDXW = 3;

  typedef logic [NSRC-1:0] src_vec_t;

  // index of the lowest set bit; 0 when the vector is empty
  function automatic logic [IDXW-1:0] lowest_set(input src_vec_t v);
    logic [IDXW-1:0] idx;
    idx = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (v[i]) idx = IDXW'(i);
    end
    return idx;
  endfunction

  // one-hot vector for a source index
  function automatic src_vec_t onehot_of(input logic [IDXW-1:0] idx);
    return src_vec_t'(1) << idx;
  endfunction
endpackage

// File: rtl/irq_phase.sv
module irq_phase #(
  parameter int LEN  = 12,
  parameter int SLOT = 8
) (
  input  logic clk,
  input  logic rst,
  output logic at_slot
);
  localparam int W = $clog2(LEN);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                        cnt_q <= '0;
    else if (cnt_q == W'(LEN - 1))  cnt_q <= '0;
    else                            cnt_q <= cnt_q + 1'b1;
  end

  assign at_slot = (cnt_q == W'(SLOT));

  // R4
  phase_range_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= W'(LEN - 1));
endmodule

// File: rtl/irq_ext_sense.sv
module irq_ext_sense (
  input  logic clk,
  input  logic rst,
  input  logic at_slot,
  input  logic pin_n,
  input  logic edge_mode,
  input  logic clr,
  output logic req
);
  logic prev_q;
  logic flag_q;
  logic fall;

  assign fall = at_slot & prev_q & ~pin_n;
  assign req  = edge_mode ? (flag_q | fall) : ~pin_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= 1'b1;
      flag_q <= 1'b0;
    end else begin
      if (at_slot) prev_q <= pin_n;
      if (!edge_mode)  flag_q <= 1'b0;
      else if (clr)    flag_q <= 1'b0;
      else if (fall)   flag_q <= 1'b1;
    end
  end

  // R8
  edge_clear_chk: assert property (@(posedge clk) disable iff (rst)
    clr |=> !flag_q);

  // R8
  edge_slot_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(flag_q) |-> $past(at_slot));
endmodule

// File: rtl/irq_select.sv
module irq_select
  import irq_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            at_slot,
  input  logic            hold,
  input  logic            reti,
  input  logic            glob,
  input  src_vec_t        req,
  input  src_vec_t        en,
  input  src_vec_t        prio,
  output src_vec_t        grant,
  output logic            take_q,
  output logic [IDXW-1:0] vec_q,
  output logic            lvl_q
);
  logic [1:0]      ins_q;
  src_vec_t        elig;
  src_vec_t        hi;
  src_vec_t        lo;
  logic            pick_hi;
  logic            pick_lo;
  logic            fire;
  logic [IDXW-1:0] win;

  assign elig    = glob ? (req & en) : '0;
  assign hi      = elig & prio;
  assign lo      = elig & ~prio;
  assign pick_hi = (|hi) && !ins_q[1];
  assign pick_lo = (|lo) && (ins_q == 2'b00);
  assign fire    = at_slot && !hold && (pick_hi || pick_lo);
  assign win     = pick_hi ? lowest_set(hi) : lowest_set(lo);
  assign grant   = fire ? onehot_of(win) : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      ins_q  <= 2'b00;
      take_q <= 1'b0;
      vec_q  <= '0;
      lvl_q  <= 1'b0;
    end else begin
      take_q <= fire;
      if (fire) begin
        vec_q <= win;
        lvl_q <= pick_hi;
        ins_q <= ins_q | (pick_hi ? 2'b10 : 2'b01);
      end else if (reti) begin
        ins_q <= ins_q[1] ? {1'b0, ins_q[0]} : 2'b00;
      end
    end
  end

  // R9
  lvl1_no_preempt_chk: assert property (@(posedge clk) disable iff (rst)
    ins_q[1] |-> !fire);

  // R9
  lvl0_nest_chk: assert property (@(posedge clk) disable iff (rst)
    (fire && ins_q[0]) |-> pick_hi);

  // R5
  level_rank_chk: assert property (@(posedge clk) disable iff (rst)
    (fire && !pick_hi) |-> (hi == '0));

  // R2
  glob_gate_chk: assert property (@(posedge clk) disable iff (rst)
    take_q |-> $past(glob));

  // R6
  grant_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant));

  // R11
  defer_chk: assert property (@(posedge clk) disable iff (rst)
    fire |-> !hold);

  // R10
  reti_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (reti && ins_q[1]) |=> !ins_q[1]);
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_pkg::*;
#(
  parameter int CYCLE_LEN   = 12,
  parameter int SAMPLE_SLOT = 8,
  parameter int NUM_EXT     = 2,
  parameter int AW          = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [1:0]      ext_n_i,
  input  logic [1:0]      tmr_ovf_i,
  input  logic            ser_i,
  input  logic            wr_en_i,
  input  logic [AW-1:0]   wr_addr_i,
  input  logic [NSRC:0]   wr_data_i,
  input  logic            reti_i,
  output logic            take_o,
  output logic [IDXW-1:0] vec_o,
  output logic            lvl_o
);
  localparam logic [AW-1:0] ADDR_EN   = AW'(0);
  localparam logic [AW-1:0] ADDR_PRIO = AW'(1);
  localparam logic [AW-1:0] ADDR_MODE = AW'(2);

  src_vec_t           en_q;
  src_vec_t           prio_q;
  logic               glob_q;
  logic [NUM_EXT-1:0] mode_q;
  logic               blk_q;
  logic               at_slot;
  logic               evt;
  logic               hold;
  logic [NUM_EXT-1:0] ext_req;
  logic [NUM_EXT-1:0] ext_clr;
  src_vec_t           req;
  src_vec_t           grant;

  irq_phase #(.LEN(CYCLE_LEN), .SLOT(SAMPLE_SLOT)) u_phase (
    .clk(clk), .rst(rst), .at_slot(at_slot)
  );

  // external pins occupy even source indices 0 and 2
  assign ext_clr[0] = grant[0];
  assign ext_clr[1] = grant[2];

  for (genvar g = 0; g < NUM_EXT; g++) begin : g_ext
    irq_ext_sense u_sense (
      .clk(clk), .rst(rst), .at_slot(at_slot),
      .pin_n(ext_n_i[g]), .edge_mode(mode_q[g]),
      .clr(ext_clr[g]), .req(ext_req[g])
    );
  end

  assign req = {ser_i, tmr_ovf_i[1], ext_req[1], tmr_ovf_i[0], ext_req[0]};

  assign evt  = reti_i ||
                (wr_en_i && (wr_addr_i == ADDR_EN || wr_addr_i == ADDR_PRIO));
  assign hold = blk_q || evt;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= '0;
      prio_q <= '0;
      glob_q <= 1'b0;
      mode_q <= '0;
      blk_q  <= 1'b0;
    end else begin
      blk_q <= at_slot ? 1'b0 : (blk_q || evt);
      if (wr_en_i) begin
        case (wr_addr_i)
          ADDR_EN: begin
            en_q   <= wr_data_i[NSRC-1:0];
            glob_q <= wr_data_i[NSRC];
          end
          ADDR_PRIO: prio_q <= wr_data_i[NSRC-1:0];
          ADDR_MODE: mode_q <= wr_data_i[NUM_EXT-1:0];
          default: ;
        endcase
      end
    end
  end

  irq_select u_select (
    .clk(clk), .rst(rst), .at_slot(at_slot), .hold(hold), .reti(reti_i),
    .glob(glob_q), .req(req), .en(en_q), .prio(prio_q), .grant(grant),
    .take_q(take_o), .vec_q(vec_o), .lvl_q(lvl_o)
  );

  // R4
  slot_align_chk: assert property (@(posedge clk) disable iff (rst)
    take_o |-> $past(at_slot));

  // R11
  reti_defer_chk: assert property (@(posedge clk) disable iff (rst)
    take_o |-> !$past(reti_i));
endmodule

// File: tb/test_irq_arbiter.sv
module test_irq_arbiter;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] ext_n = 2'b11;
  logic [1:0] tmr = 2'b00;
  logic       ser = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = 2'b00;
  logic [5:0] wr_data = 6'd0;
  logic       reti = 1'b0;
  logic       take;
  logic [2:0] vec;
  logic       lvl;

  int nchk = 0;
  int nerr = 0;
  bit done = 1'b0;
  int bph = 0;

  always #2.5 clk = ~clk;

  irq_arbiter i_irq_arbiter (
    .clk(clk), .rst(rst), .ext_n_i(ext_n), .tmr_ovf_i(tmr), .ser_i(ser),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .reti_i(reti), .take_o(take), .vec_o(vec), .lvl_o(lvl)
  );

  // independent machine-cycle position, counted from reset release
  always @(posedge clk) begin
    if (rst) bph <= 0;
    else     bph <= (bph == 11) ? 0 : bph + 1;
  end

  // output code: 0 = no take, else 16 + 8*level + index
  function automatic int obs();
    return take ? (16 + (lvl ? 8 : 0) + int'(vec)) : 0;
  endfunction

  // winner by score: level weighs 8, earlier poll position weighs more
  function automatic int expect_win(input logic [4:0] p, input logic [4:0] r);
    int best = -1;
    int score = -1;
    for (int i = 0; i < 5; i++) begin
      if (r[i] && (int'(p[i]) * 8 + (7 - i)) > score) begin
        score = int'(p[i]) * 8 + (7 - i);
        best = i;
      end
    end
    if (best < 0) return 0;
    return 16 + int'(p[best]) * 8 + best;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic next_slot();
    @(negedge clk);
    while (bph != 9) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [5:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pulse_reti();
    reti = 1'b1;
    @(negedge clk);
    reti = 1'b0;
  endtask

  task automatic set_req(input logic [4:0] r);
    ext_n[0] = ~r[0]; tmr[0] = r[1]; ext_n[1] = ~r[2]; tmr[1] = r[3]; ser = r[4];
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nchk++; nerr++;
      $display("FAIL watchdog actual=running expected=finished");
      finish_run();
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    chk("R1 idle after reset", obs(), 0);
    set_req(5'b11111);
    next_slot();
    chk("R1 nothing enabled", obs(), 0);

    // R2: sources enabled, global clear
    wr(2'd0, 6'b011111);
    next_slot();
    chk("R2 global off (held)", obs(), 0);
    next_slot();
    chk("R2 global off", obs(), 0);
    wr(2'd0, 6'b111111);
    next_slot();
    chk("R11 enable write defers", obs(), 0);
    next_slot();
    chk("R6 ext0 first in order", obs(), 16);
    set_req(5'b00000);
    pulse_reti();

    // R3: ext0 disabled, timer0 wins
    wr(2'd0, 6'b111110);
    set_req(5'b11111);
    next_slot();
    next_slot();
    chk("R3 disabled source skipped", obs(), 17);
    set_req(5'b00000);
    pulse_reti();

    // R4: strobe timing around the sample edge
    wr(2'd0, 6'b111111);
    next_slot();
    set_req(5'b01000);
    while (bph != 8) @(negedge clk);
    chk("R4 low before slot", int'(take), 0);
    @(negedge clk);
    chk("R4 strobe after slot", obs(), 19);
    @(negedge clk);
    chk("R4 strobe one clock", int'(take), 0);
    set_req(5'b00000);
    pulse_reti();
    next_slot();

    // R5 R6: every priority setting against every request pattern
    for (int p = 0; p < 32; p++) begin
      for (int r = 0; r < 32; r++) begin
        wr(2'd1, {1'b0, 5'(p)});
        set_req(5'(r));
        next_slot();
        if (take) chk("R11 priority write defers", obs(), 0);
        next_slot();
        chk("R5 R6 sweep", obs(), expect_win(5'(p), 5'(r)));
        set_req(5'b00000);
        if (take) pulse_reti();
      end
    end
    wr(2'd1, 6'd0);
    next_slot();

    // R7: level mode, short pulse between samples is lost
    ext_n[0] = 1'b0;
    repeat (3) @(negedge clk);
    ext_n[0] = 1'b1;
    next_slot();
    chk("R7 short pulse missed", obs(), 0);
    ext_n[0] = 1'b0;
    repeat (12) @(negedge clk);
    chk("R7 full cycle seen", obs(), 16);
    ext_n[0] = 1'b1;
    pulse_reti();
    next_slot();

    // R8 with R11: edge mode; mode write does not defer
    wr(2'd2, 6'b000001);
    ext_n[0] = 1'b0;
    next_slot();
    chk("R8 falling edge taken, R11 mode write no defer", obs(), 16);
    pulse_reti();
    next_slot();
    next_slot();
    chk("R8 held low no retake", obs(), 0);
    ext_n[0] = 1'b1;
    next_slot();
    chk("R8 high no request", obs(), 0);
    ext_n[0] = 1'b0;
    next_slot();
    chk("R8 second edge taken", obs(), 16);
    ext_n[0] = 1'b1;
    pulse_reti();
    next_slot();
    ext_n[0] = 1'b0;
    repeat (3) @(negedge clk);
    ext_n[0] = 1'b1;
    next_slot();
    chk("R8 short edge pulse missed", obs(), 0);
    wr(2'd2, 6'b000000);

    // R9 R10: nesting
    wr(2'd1, 6'b000100);
    next_slot();
    set_req(5'b00001);
    next_slot();
    chk("R9 level0 taken", obs(), 16);
    set_req(5'b00011);
    next_slot();
    chk("R9 level0 not preempting level0", obs(), 0);
    set_req(5'b00111);
    next_slot();
    chk("R9 level1 preempts", obs(), 26);
    next_slot();
    chk("R9 level1 in service blocks", obs(), 0);
    wr(2'd1, 6'b000110);
    next_slot();
    next_slot();
    chk("R9 level1 not preempted by level1", obs(), 0);
    set_req(5'b00001);
    pulse_reti();
    next_slot();
    chk("R11 return defers", obs(), 0);
    next_slot();
    chk("R10 level0 still in service", obs(), 0);
    pulse_reti();
    next_slot();
    chk("R11 return defers again", obs(), 0);
    next_slot();
    chk("R10 level0 cleared", obs(), 16);
    set_req(5'b00000);
    pulse_reti();
    next_slot();

    finish_run();
  end
endmodule